// File: doc/BRIEF.md
# Serial EEPROM Slave Front End

This block is the serial side of a 512-byte EEPROM. It works as an SPI mode 0 slave. Serial input is sampled on the rising clock edge, and serial output changes on the falling edge. The chip-select, serial-clock and data inputs are resynchronised into the system clock domain, and every decision is taken on the detected edges.

A transaction opens on a chip-select falling edge. The first byte is the command, and the ninth address bit rides inside the command byte. For a memory access, the low address byte follows. Reads stream data continuously, and the address wraps past the top of the array. Writes collect up to one 8-byte page and hand it to an internal page-program engine when chip select rises. The engine then runs a timed program cycle and commits the bytes into an internal register array.

A status byte reports whether a cycle is running, whether writing is enabled, and the block-protection level. A protection level locks the upper quarter, the upper half or the whole array against writes.

Top module: `eeprom_spi_top`

## Requirements
- R1: After reset the serial output enable is low and the status byte reads 0x00. The status byte is laid out as: bit 0 = cycle running, bit 1 = write enabled, bits 3:2 = protection level, bits 7:4 = 0.
- R2: A command byte has its upper nibble 0, bit 3 = A8 for memory accesses, and its low three bits select the command: 011 read, 010 write, 110 enable writes, 100 disable writes, 101 read status, 001 write status. Read data follows the address byte MSB first. The output enable is high only while chip select is low and a byte is being driven.
- R3: While chip select stays low, a read keeps returning the following addresses, and address 0x1FF is followed by 0x000.
- R4: The enable command sets status bit 1, and the disable command clears it.
- R5: A write or status-write issued while writing is disabled changes no memory, starts no cycle, and ignores the rest of that transaction.
- R6: Within a write, the low three address bits step after each data byte and wrap inside the 8-byte page, so later bytes overwrite earlier ones. The upper six bits stay fixed.
- R7: A cycle starts on chip-select rise. Status bit 0 reads 1 while the cycle runs and 0 after it ends, and bit 1 clears when the cycle starts.
- R8: While a cycle runs, every command other than read-status is ignored: reads drive no output and the enable command has no effect.
- R9: Write-status loads bits 3:2 of its data byte as the protection level once its cycle ends. Level 1 protects 0x180-0x1FF, level 2 protects 0x100-0x1FF, and level 3 protects the whole array. Bytes aimed at protected addresses are not stored.
- R10: A write whose chip select rises part-way through a data byte starts no cycle and leaves writing enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block (0 when not enabled) |
| spi_miso_oe | output | 1 | Output enable for spi_miso (high-impedance when low) |

## Verification
A wrong command or address state shows at the ports within the byte that follows. A bad address step or wrap returns the wrong data byte on the very next serial byte. A wrongly accepted command during a cycle shows up as an output enable where none is expected, or as a stray write-enable bit in the next status read. Page-wrap, protection and partial-byte faults stay hidden until the program cycle ends, and appear on the first read-back of the affected addresses.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDAT, ST_WDAT, ST_STAT, ST_SRWR, ST_IGN
  } fe_state_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR
  } op_t;

  typedef enum logic [1:0] {
    PG_IDLE, PG_WAIT, PG_DRAIN
  } pg_phase_t;

  // upper nibble must be clear; bit 3 is address/don't care
  function automatic op_t decode_op(input logic [7:0] b);
    if (b[7:4] != 4'h0) return OP_NONE;
    case (b[2:0])
      3'b011:  return OP_READ;
      3'b010:  return OP_WRITE;
      3'b110:  return OP_WREN;
      3'b100:  return OP_WRDI;
      3'b101:  return OP_RDSR;
      3'b001:  return OP_WRSR;
      default: return OP_NONE;
    endcase
  endfunction

  // protection from the two top address bits and the level
  function automatic logic blk_protected(input logic [1:0] lvl, input logic [1:0] top2);
    case (lvl)
      2'd1:    return top2 == 2'b11;
      2'd2:    return top2[1];
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] status_byte(input logic [1:0] lvl, input logic wel,
                                             input logic busy);
    return {4'h0, lvl, wel, busy};
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int    STAGES  = 2,
  parameter logic  RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_page_prog.sv
module eeprom_page_prog import eeprom_spi_pkg::*; #(
  parameter int AW          = 9,
  parameter int PW          = 3,
  parameter int PROG_CYCLES = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_clear,
  input  logic [AW-PW-1:0] pg_base,
  input  logic             pg_load,
  input  logic [PW-1:0]    pg_slot,
  input  logic [7:0]       pg_data,
  input  logic             pg_start,
  input  logic             sr_start,
  input  logic [1:0]       sr_lvl,
  output logic             busy,
  output logic [1:0]       lvl,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [7:0]       mem_wdata
);
  localparam int NSLOT = 1 << PW;
  localparam int TW    = $clog2(PROG_CYCLES + 1);

  pg_phase_t        phase;
  logic [TW-1:0]    tmr;
  logic [PW-1:0]    idx;
  logic [AW-PW-1:0] base;
  logic             pend_sr;
  logic [1:0]       pend_lvl;
  logic [7:0]       pbuf [NSLOT];
  logic [NSLOT-1:0] vld;
  logic             drain_last;

  assign drain_last = (phase == PG_DRAIN) && (idx == PW'(NSLOT - 1));

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld[s]  <= 1'b0;
          pbuf[s] <= 8'h00;
        end else if (pg_clear || drain_last) begin
          vld[s] <= 1'b0;
        end else if (pg_load && pg_slot == PW'(s)) begin
          vld[s]  <= 1'b1;
          pbuf[s] <= pg_data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PG_IDLE;
      tmr      <= '0;
      idx      <= '0;
      base     <= '0;
      pend_sr  <= 1'b0;
      pend_lvl <= 2'd0;
      lvl      <= 2'd0;
    end else begin
      if (pg_clear) base <= pg_base;
      case (phase)
        PG_IDLE: begin
          if (pg_start || sr_start) begin
            phase    <= PG_WAIT;
            tmr      <= TW'(PROG_CYCLES - 1);
            pend_sr  <= sr_start;
            pend_lvl <= sr_lvl;
          end
        end
        PG_WAIT: begin
          if (tmr == '0) begin
            if (pend_sr) begin
              lvl   <= pend_lvl;
              phase <= PG_IDLE;
            end else begin
              idx   <= '0;
              phase <= PG_DRAIN;
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        PG_DRAIN: begin
          idx <= idx + 1'b1;
          if (drain_last) phase <= PG_IDLE;
        end
        default: phase <= PG_IDLE;
      endcase
    end
  end

  assign busy      = (phase != PG_IDLE);
  assign mem_we    = (phase == PG_DRAIN) && vld[idx];
  assign mem_waddr = {base, idx};
  assign mem_wdata = pbuf[idx];
endmodule

// File: rtl/eeprom_spi_frontend.sv
module eeprom_spi_frontend import eeprom_spi_pkg::*; #(
  parameter int AW = 9,
  parameter int PW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             mosi_s,
  input  logic             busy,
  input  logic [1:0]       lvl,
  input  logic [7:0]       rd_data,
  output logic [AW-1:0]    rd_addr,
  output logic             miso_bit,
  output logic             miso_oe,
  output logic             wel,
  output logic             pg_clear,
  output logic [AW-PW-1:0] pg_base,
  output logic             pg_load,
  output logic [PW-1:0]    pg_slot,
  output logic [7:0]       pg_data,
  output logic             pg_start,
  output logic             sr_start,
  output logic [1:0]       sr_lvl
);
  fe_state_t     state;
  logic [2:0]    bcnt, out_cnt;
  logic [7:0]    sh_in, out_sh;
  logic          a8, is_rd, out_live, got_q, sr_got;
  logic [AW-1:0] addr_q;
  logic [1:0]    sr_val;

  logic [7:0]    in_byte;
  logic          shifting, byte_done;
  op_t           cmd;
  logic [AW-1:0] addr_new;

  assign in_byte   = {sh_in[6:0], mosi_s};
  assign shifting  = sck_rise && (state == ST_OPC || state == ST_ADDR ||
                                  state == ST_WDAT || state == ST_SRWR);
  assign byte_done = shifting && (bcnt == 3'd7);
  assign cmd       = decode_op(in_byte);
  assign addr_new  = AW'({a8, in_byte});

  assign pg_clear  = byte_done && state == ST_ADDR && !is_rd;
  assign pg_base   = addr_new[AW-1:PW];
  assign pg_load   = byte_done && state == ST_WDAT &&
                     !blk_protected(lvl, addr_q[AW-1 -: 2]);
  assign pg_slot   = addr_q[PW-1:0];
  assign pg_data   = in_byte;
  assign pg_start  = cs_rise && state == ST_WDAT && got_q && bcnt == 3'd0;
  assign sr_start  = cs_rise && sr_got;
  assign sr_lvl    = sr_val;

  assign rd_addr   = addr_q;
  assign miso_bit  = out_sh[7];
  assign miso_oe   = out_live && (state == ST_RDAT || state == ST_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (pg_start || sr_start) begin
      wel <= 1'b0;
    end else if (byte_done && state == ST_OPC && !busy) begin
      if (cmd == OP_WREN)      wel <= 1'b1;
      else if (cmd == OP_WRDI) wel <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bcnt     <= '0;
      out_cnt  <= '0;
      sh_in    <= '0;
      out_sh   <= '0;
      a8       <= 1'b0;
      is_rd    <= 1'b0;
      out_live <= 1'b0;
      got_q    <= 1'b0;
      sr_got   <= 1'b0;
      sr_val   <= 2'd0;
      addr_q   <= '0;
    end else if (cs_fall) begin
      state    <= ST_OPC;
      bcnt     <= '0;
      out_cnt  <= '0;
      out_live <= 1'b0;
      got_q    <= 1'b0;
      sr_got   <= 1'b0;
    end else if (cs_rise) begin
      state    <= ST_IDLE;
      out_live <= 1'b0;
      sr_got   <= 1'b0;
    end else begin
      if (shifting) begin
        sh_in <= in_byte;
        bcnt  <= bcnt + 1'b1;
      end
      case (state)
        ST_OPC: if (byte_done) begin
          a8 <= in_byte[3];
          if (busy && cmd != OP_RDSR) state <= ST_IGN;
          else begin
            case (cmd)
              OP_READ:  begin is_rd <= 1'b1; state <= ST_ADDR; end
              OP_WRITE: begin is_rd <= 1'b0; state <= wel ? ST_ADDR : ST_IGN; end
              OP_RDSR:  state <= ST_STAT;
              OP_WRSR:  state <= wel ? ST_SRWR : ST_IGN;
              default:  state <= ST_IGN;
            endcase
          end
        end
        ST_ADDR: if (byte_done) begin
          addr_q <= addr_new;
          state  <= is_rd ? ST_RDAT : ST_WDAT;
        end
        ST_WDAT: if (byte_done) begin
          addr_q[PW-1:0] <= addr_q[PW-1:0] + 1'b1;
          got_q          <= 1'b1;
        end
        ST_SRWR: if (byte_done) begin
          sr_val <= in_byte[3:2];
          sr_got <= 1'b1;
          state  <= ST_IGN;
        end
        ST_RDAT, ST_STAT: if (sck_fall) begin
          out_cnt <= out_cnt + 1'b1;
          if (out_cnt == 3'd0) begin
            out_live <= 1'b1;
            if (state == ST_RDAT) begin
              out_sh <= rd_data;
              addr_q <= addr_q + 1'b1;
            end else begin
              out_sh <= status_byte(lvl, wel, busy);
            end
          end else begin
            out_sh <= {out_sh[6:0], 1'b0};
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_spi_top.sv
module eeprom_spi_top import eeprom_spi_pkg::*; #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 3,
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic cs_s, sck_s, mosi_s, cs_prev, sck_prev;
  logic cs_fall_w, cs_rise_w, sck_rise_w, sck_fall_w;

  spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync
    (.clk(clk), .rst_n(rst_n), .d(spi_cs_n), .q(cs_s));
  spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync
    (.clk(clk), .rst_n(rst_n), .d(spi_sck), .q(sck_s));
  spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mosi_sync
    (.clk(clk), .rst_n(rst_n), .d(spi_mosi), .q(mosi_s));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_prev  <= cs_s;
      sck_prev <= sck_s;
    end

  assign cs_fall_w  = cs_prev && !cs_s;
  assign cs_rise_w  = !cs_prev && cs_s;
  assign sck_rise_w = !cs_s && !sck_prev && sck_s;
  assign sck_fall_w = !cs_s && sck_prev && !sck_s;

  logic                    prog_busy, wel_w, miso_bit, miso_oe_w;
  logic [1:0]              lvl_w, sr_lvl;
  logic [7:0]              rd_data, pg_data, mem_wdata;
  logic [ADDR_W-1:0]       rd_addr, mem_waddr;
  logic                    pg_clear, pg_load, pg_start, sr_start, mem_we;
  logic [PAGE_W-1:0]       pg_slot;
  logic [ADDR_W-PAGE_W-1:0] pg_base;

  eeprom_spi_frontend #(.AW(ADDR_W), .PW(PAGE_W)) u_fe (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(cs_fall_w), .cs_rise(cs_rise_w),
    .sck_rise(sck_rise_w), .sck_fall(sck_fall_w), .mosi_s(mosi_s),
    .busy(prog_busy), .lvl(lvl_w), .rd_data(rd_data), .rd_addr(rd_addr),
    .miso_bit(miso_bit), .miso_oe(miso_oe_w), .wel(wel_w),
    .pg_clear(pg_clear), .pg_base(pg_base), .pg_load(pg_load),
    .pg_slot(pg_slot), .pg_data(pg_data), .pg_start(pg_start),
    .sr_start(sr_start), .sr_lvl(sr_lvl)
  );

  eeprom_page_prog #(.AW(ADDR_W), .PW(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n),
    .pg_clear(pg_clear), .pg_base(pg_base), .pg_load(pg_load),
    .pg_slot(pg_slot), .pg_data(pg_data), .pg_start(pg_start),
    .sr_start(sr_start), .sr_lvl(sr_lvl), .busy(prog_busy), .lvl(lvl_w),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  eeprom_cell_array #(.AW(ADDR_W)) u_cells (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .raddr(rd_addr), .rdata(rd_data)
  );

  assign spi_miso_oe = miso_oe_w;
  assign spi_miso    = miso_oe_w ? miso_bit : 1'b0;
endmodule

// File: rtl/eeprom_spi_chk.sv
module eeprom_spi_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_rise,
  input logic miso_oe,
  input logic busy,
  input logic pg_load,
  input logic pg_start,
  input logic sr_start,
  input logic wel
);
  // R2
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !miso_oe);

  // R8
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pg_load);

  // R7
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_start || sr_start) |=> !wel);

  // R7
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pg_start || sr_start));

  // R5
  load_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_load |-> wel);
endmodule

bind eeprom_spi_top eeprom_spi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise_w), .miso_oe(miso_oe_w),
  .busy(prog_busy), .pg_load(pg_load), .pg_start(pg_start),
  .sr_start(sr_start), .wel(wel_w)
);

// File: tb/eeprom_spi_top_test.sv
module eeprom_spi_top_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;

  always #10 clk = ~clk;

  eeprom_spi_top uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
  );

  typedef struct { logic [7:0] d; logic oe; string tag; } exp_t;
  typedef struct { logic [7:0] d; logic any_oe; logic all_oe; } got_t;
  exp_t exp_q[$];
  got_t got_q[$];

  int checks = 0, errors = 0;
  logic [7:0] ref_mem [512];
  logic [1:0] lvl_m = 2'd0;
  logic       wel_m = 1'b0;
  logic       done = 1'b0;

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(logic ok, string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compares results as they arrive
  initial forever begin
    exp_t e; got_t g;
    wait (got_q.size() != 0);
    g = got_q.pop_front();
    e = exp_q.pop_front();
    if (e.oe) check(g.all_oe && g.d == e.d, e.tag, g.d, e.d);
    else      check(!g.any_oe, {e.tag, " (output enable)"}, {7'd0, g.any_oe}, 8'h00);
  end

  task automatic xfer(input logic [7:0] tx, output got_t g);
    g.d = 8'h00; g.any_oe = 1'b0; g.all_oe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      tick(HALF);
      g.d = {g.d[6:0], spi_miso};
      g.any_oe |= spi_miso_oe;
      g.all_oe &= spi_miso_oe;
      spi_sck = 1'b1;
      tick(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic cs_on;  spi_cs_n = 1'b0; tick(6); endtask
  task automatic cs_off; tick(6); spi_cs_n = 1'b1; tick(12); endtask

  task automatic cmd1(input logic [7:0] op);
    got_t g;
    cs_on; xfer(op, g); cs_off;
  endtask

  task automatic rdsr(output logic [7:0] s);
    got_t g;
    cs_on; xfer(8'h05, g); xfer(8'h00, g); cs_off;
    s = g.d;
  endtask

  task automatic expect_status(input logic [7:0] e, input string tag);
    got_t g;
    cs_on; xfer(8'h05, g);
    exp_q.push_back('{d: e, oe: 1'b1, tag: tag});
    xfer(8'h00, g); got_q.push_back(g);
    cs_off;
  endtask

  task automatic wait_idle;
    logic [7:0] s;
    for (int k = 0; k < 200; k++) begin
      rdsr(s);
      if (!s[0]) return;
    end
    check(1'b0, "R7 cycle never ended", 8'h01, 8'h00);
  endtask

  task automatic read_seq(input logic [8:0] a, input int n, input string tag, input logic live);
    got_t g;
    logic [8:0] p = a;
    cs_on;
    xfer({4'h0, a[8], 3'b011}, g);
    xfer(a[7:0], g);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{d: ref_mem[p], oe: live, tag: tag});
      xfer(8'h00, g);
      got_q.push_back(g);
      p = p + 9'd1;
    end
    cs_off;
  endtask

  function automatic logic prot(logic [1:0] l, logic [8:0] a);
    return (l == 2'd3) || (l == 2'd2 && a >= 9'd256) || (l == 2'd1 && a >= 9'd384);
  endfunction

  task automatic write_seq(input logic [8:0] a, input logic [7:0] d [16], input int n);
    got_t g;
    logic [2:0] slot = a[2:0];
    cs_on;
    xfer({4'h0, a[8], 3'b010}, g);
    xfer(a[7:0], g);
    for (int i = 0; i < n; i++) begin
      xfer(d[i], g);
      if (wel_m && !prot(lvl_m, {a[8:3], slot})) ref_mem[{a[8:3], slot}] = d[i];
      slot = slot + 3'd1;
    end
    cs_off;
    if (wel_m && n > 0) begin wel_m = 1'b0; wait_idle; end
  endtask

  task automatic write1(input logic [8:0] a, input logic [7:0] v);
    logic [7:0] d [16];
    foreach (d[i]) d[i] = 8'h00;
    d[0] = v;
    write_seq(a, d, 1);
  endtask

  task automatic wren; cmd1(8'h06); wel_m = 1'b1; endtask

  task automatic wrsr(input logic [7:0] v);
    got_t g;
    cs_on; xfer(8'h01, g); xfer(v, g); cs_off;
    if (wel_m) begin lvl_m = v[3:2]; wel_m = 1'b0; wait_idle; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [16];
    got_t g;
    foreach (ref_mem[i]) ref_mem[i] = 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    check(spi_miso_oe == 1'b0, "R1 output enable after reset", {7'd0, spi_miso_oe}, 8'h00);
    expect_status(8'h00, "R1 status after reset");
    read_seq(9'h005, 1, "R2 erased read", 1'b1);

    // enable and page write of four bytes
    wren;
    expect_status(8'h02, "R4 enable sets bit 1");
    d = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    cs_on;
    xfer(8'h02, g); xfer(8'h10, g);
    for (int i = 0; i < 4; i++) begin xfer(d[i], g); ref_mem[9'h010 + i] = d[i]; end
    cs_off;
    wel_m = 1'b0;
    expect_status(8'h01, "R7 busy with write enable cleared");
    cmd1(8'h06);
    read_seq(9'h010, 1, "R8 read ignored while busy", 1'b0);
    wait_idle;
    expect_status(8'h00, "R8 enable ignored while busy");
    read_seq(9'h010, 4, "R2 R3 sequential read", 1'b1);

    // page wrap with ten bytes, upper page (A8 set)
    wren;
    for (int i = 0; i < 16; i++) d[i] = 8'h40 + 8'(i);
    write_seq(9'h11E, d, 10);
    read_seq(9'h118, 9, "R6 page wrap", 1'b1);

    // wrap of continuous read past the top
    wren; write1(9'h1FF, 8'h5A);
    wren; write1(9'h000, 8'h33);
    read_seq(9'h1FE, 3, "R3 wrap to zero", 1'b1);

    // write with writing disabled
    write1(9'h020, 8'h77);
    expect_status(8'h00, "R5 no cycle when disabled");
    read_seq(9'h020, 1, "R5 memory unchanged", 1'b1);
    wrsr(8'h0C);
    expect_status(8'h00, "R5 status write ignored when disabled");

    // disable command
    wren;
    cmd1(8'h04); wel_m = 1'b0;
    expect_status(8'h00, "R4 disable clears bit 1");

    // partial data byte
    wren;
    cs_on;
    xfer(8'h02, g); xfer(8'h30, g); xfer(8'h99, g);
    for (int i = 0; i < 3; i++) begin
      spi_mosi = 1'b1; tick(HALF); spi_sck = 1'b1; tick(HALF); spi_sck = 1'b0;
    end
    cs_off;
    expect_status(8'h02, "R10 partial byte keeps enable, no cycle");
    read_seq(9'h030, 1, "R10 partial byte not stored", 1'b1);
    cmd1(8'h04); wel_m = 1'b0;

    // protection levels
    wren; wrsr(8'h04);
    expect_status(8'h04, "R9 level 1 loaded");
    wren; write1(9'h180, 8'h11);
    wren; write1(9'h17F, 8'h22);
    read_seq(9'h17F, 2, "R9 level 1 boundary", 1'b1);
    wren; wrsr(8'h08);
    wren; write1(9'h100, 8'h44);
    wren; write1(9'h0FF, 8'h55);
    read_seq(9'h0FF, 2, "R9 level 2 boundary", 1'b1);
    wren; wrsr(8'h0C);
    expect_status(8'h0C, "R9 level 3 loaded");
    wren; write1(9'h000, 8'h66);
    read_seq(9'h000, 1, "R9 level 3 all locked", 1'b1);
    wren; wrsr(8'h00);
    expect_status(8'h00, "R9 level cleared");

    wait (got_q.size() == 0);
    tick(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule